// File: doc/BRIEF.md
# Stack push-multiple store sequencer

This block takes one store-multiple-to-stack instruction at a time and turns it into a run of 32-bit word stores. It accepts two encodings: a single 32-bit word form and a two-halfword form, with the first halfword in bits 31:16. A separate input says which form is presented, because some bit patterns are legal in both. An external pass input carries the outcome of condition evaluation. A word that does not decode as a push completes at once and is flagged as not-a-push.

For a valid push, the block counts the registers in the list and computes the lowest address of the frame at the start: the old stack pointer minus four bytes per register. It then walks the list from the lowest register number to the highest. Each register value is read through a combinational register-file read port and sent on a valid/ready memory write port, and the address rises by four after every accepted store. One cycle after the last store is accepted, the new stack pointer (the frame base) is written back. A done pulse comes in that same cycle.

Top module: `stack_push_seq`

## Requirements
- R1: With `insn_form`=0 the word is a push candidate only when bits 31:28 are not 1111, bits 27:20 are 1001_0010 and bits 19:16 are 1101. The list is bits 15:0, bit n standing for register n.
- R2: With `insn_form`=1 the word is a push candidate only when bits 31:16 are 0xE92D and bits 15 and 13 are both 0. Bits 12:0 select registers 0 to 12, and bit 14 selects register 14.
- R3: A candidate is a push only when its register list has more than one bit set. Otherwise it is treated as not-a-push.
- R4: An accepted not-a-push word gives `done`=1 and `not_push`=1 in the cycle after acceptance. It makes no store and no stack-pointer write.
- R5: An accepted push with `insn_pass`=0 gives `done`=1 with `not_push`=0 in the cycle after acceptance. It makes no store and no stack-pointer write.
- R6: Stores go out in ascending register order, one register per accepted transfer (`mem_wvalid` and `mem_wready` both high). The first address is the old stack pointer minus 4×N, where N is the number of registers, and each later store is 4 higher.
- R7: Each store carries the value the register file returns for `rf_raddr`, which equals the register number of that store. When register 13 is in the list but is not the lowest, its stored value is unspecified.
- R8: While `mem_wready` is low, `mem_wvalid`, `mem_waddr` and `rf_raddr` hold their values.
- R9: In the cycle after the last store is accepted, `sp_we` and `done` are high for exactly one cycle, and `sp_wdata` equals the old stack pointer minus 4×N.
- R10: `insn_ready` is high only while idle. An instruction presented while stores are in progress is ignored.
- R11: After reset, `insn_ready`=1 and `mem_wvalid`, `done` and `sp_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction offered |
| insn_word | input | 32 | Instruction bits |
| insn_form | input | 1 | 0 = word form, 1 = two-halfword form |
| insn_pass | input | 1 | Condition passed |
| insn_ready | output | 1 | Idle, so an instruction can be accepted |
| sp_rdata | input | ADDR_W | Current stack pointer value |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | DATA_W | Register-file read data |
| mem_wvalid | output | 1 | Store request valid |
| mem_wready | input | 1 | Store accepted |
| mem_waddr | output | ADDR_W | Store byte address |
| mem_wdata | output | DATA_W | Store data |
| sp_we | output | 1 | Stack-pointer writeback strobe |
| sp_wdata | output | ADDR_W | New stack-pointer value |
| done | output | 1 | Instruction finished |
| not_push | output | 1 | Finished instruction was not a push |

## Verification
The bench targets these corner cases:

- Words that differ from a push in a single field: the condition field is 1111, the base register is wrong, the load bit is set, or halfword bit 15 or bit 13 is set. A loose decoder would start stores for these.
- Lists with exactly one bit. A design that misses the count rule would push a single register.
- Register 13 placed lowest and not lowest, and the full 16-bit list. An ordering or address error would scramble the frame.
- Random-looking ready stalls, a pass-low push and an instruction held on the input during stores. A design that gets these wrong would drop or repeat stores, write back early or twice, or start a second instruction mid-run.

// File: rtl/spush_pkg.sv
package spush_pkg;
  localparam int unsigned NREG   = 16;
  localparam int unsigned RIDX_W = $clog2(NREG);
  localparam int unsigned CNT_W  = RIDX_W + 1;
  localparam logic [3:0]  SP_CODE = 4'd13;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_STORE = 1'b1} seq_state_t;

  // number of set bits in a register list
  function automatic logic [CNT_W-1:0] list_count(input logic [NREG-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NREG; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction
endpackage

// File: rtl/spush_decode.sv
module spush_decode
  import spush_pkg::*;
(
  input  logic [31:0]      insn,
  input  logic             form_hw,
  output logic             is_push,
  output logic [NREG-1:0]  reg_list,
  output logic [CNT_W-1:0] reg_cnt
);
  logic            word_hit;
  logic            hw_hit;
  logic [NREG-1:0] word_list;
  logic [NREG-1:0] hw_list;

  assign word_hit = (insn[31:28] != 4'hF) && (insn[27:25] == 3'b100) &&
                    insn[24] && !insn[23] && !insn[22] && insn[21] &&
                    !insn[20] && (insn[19:16] == SP_CODE);
  assign hw_hit   = (insn[31:25] == 7'b1110100) && (insn[24:23] == 2'b10) &&
                    !insn[22] && insn[21] && !insn[20] &&
                    (insn[19:16] == SP_CODE) && !insn[15] && !insn[13];

  assign word_list = insn[15:0];
  assign hw_list   = {1'b0, insn[14], 1'b0, insn[12:0]};

  assign reg_list = form_hw ? hw_list : word_list;
  assign reg_cnt  = list_count(reg_list);
  assign is_push  = (form_hw ? hw_hit : word_hit) && (reg_cnt > CNT_W'(1));
endmodule

// File: rtl/spush_pick.sv
module spush_pick
  import spush_pkg::*;
(
  input  logic [NREG-1:0]   pending,
  output logic [RIDX_W-1:0] idx,
  output logic [NREG-1:0]   onehot,
  output logic              final_one
);
  logic seen;

  always_comb begin
    onehot = '0;
    idx    = '0;
    seen   = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (pending[i] && !seen) begin
        onehot[i] = 1'b1;
        idx       = RIDX_W'(i);
        seen      = 1'b1;
      end
    end
  end

  assign final_one = ((pending & ~onehot) == '0);
endmodule

// File: rtl/stack_push_seq.sv
module stack_push_seq
  import spush_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [31:0]       insn_word,
  input  logic              insn_form,
  input  logic              insn_pass,
  output logic              insn_ready,
  input  logic [ADDR_W-1:0] sp_rdata,
  output logic [3:0]        rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              sp_we,
  output logic [ADDR_W-1:0] sp_wdata,
  output logic              done,
  output logic              not_push
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  seq_state_t        state;
  logic [NREG-1:0]   pending;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] base_q;
  logic              done_q;
  logic              nopush_q;
  logic              spwe_q;

  logic              dec_push;
  logic [NREG-1:0]   dec_list;
  logic [CNT_W-1:0]  dec_cnt;
  logic [RIDX_W-1:0] pick_idx;
  logic [NREG-1:0]   pick_onehot;
  logic              pick_last;
  logic [ADDR_W-1:0] start_addr;

  // named events for the checker
  logic ev_accept;
  logic ev_start;
  logic ev_fire;
  logic ev_last;

  spush_decode u_dec (
    .insn     (insn_word),
    .form_hw  (insn_form),
    .is_push  (dec_push),
    .reg_list (dec_list),
    .reg_cnt  (dec_cnt)
  );

  spush_pick u_pick (
    .pending   (pending),
    .idx       (pick_idx),
    .onehot    (pick_onehot),
    .final_one (pick_last)
  );

  assign start_addr = sp_rdata - ADDR_W'(dec_cnt) * STEP;

  assign insn_ready = (state == ST_IDLE);
  assign ev_accept  = insn_valid && insn_ready;
  assign ev_start   = ev_accept && dec_push && insn_pass;
  assign mem_wvalid = (state == ST_STORE);
  assign ev_fire    = mem_wvalid && mem_wready;
  assign ev_last    = ev_fire && pick_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pending  <= '0;
      addr_q   <= '0;
      base_q   <= '0;
      done_q   <= 1'b0;
      nopush_q <= 1'b0;
      spwe_q   <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      nopush_q <= 1'b0;
      spwe_q   <= 1'b0;
      if (ev_accept && !ev_start) begin
        done_q   <= 1'b1;
        nopush_q <= !dec_push;
      end
      if (ev_start) begin
        state   <= ST_STORE;
        pending <= dec_list;
        addr_q  <= start_addr;
        base_q  <= start_addr;
      end else if (ev_fire) begin
        pending <= pending & ~pick_onehot;
        addr_q  <= addr_q + STEP;
        if (pick_last) begin
          state  <= ST_IDLE;
          done_q <= 1'b1;
          spwe_q <= 1'b1;
        end
      end
    end
  end

  assign rf_raddr  = 4'(pick_idx);
  assign mem_waddr = addr_q;
  assign mem_wdata = rf_rdata;
  assign sp_we     = spwe_q;
  assign sp_wdata  = base_q;
  assign done      = done_q;
  assign not_push  = nopush_q;
endmodule

// File: rtl/spush_chk.sv
module spush_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_ready,
  input logic              mem_wvalid,
  input logic              mem_wready,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic [3:0]        rf_raddr,
  input logic              sp_we,
  input logic              done,
  input logic              not_push,
  input logic              ev_accept,
  input logic              ev_start,
  input logic              ev_fire,
  input logic              ev_last
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire && !ev_last |=> mem_waddr == $past(mem_waddr) + STEP);

  p_ascend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire && !ev_last |=> rf_raddr > $past(rf_raddr));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && !mem_wready |=> mem_wvalid && $stable(mem_waddr) && $stable(rf_raddr));

  p_wb_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> sp_we && done);

  p_wb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |=> !sp_we);

  p_wb_is_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> done && !not_push);

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> !insn_ready);

  p_quick_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && !ev_start |=> done && !mem_wvalid && !sp_we);
endmodule

bind stack_push_seq spush_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_ready (insn_ready),
  .mem_wvalid (mem_wvalid),
  .mem_wready (mem_wready),
  .mem_waddr  (mem_waddr),
  .rf_raddr   (rf_raddr),
  .sp_we      (sp_we),
  .done       (done),
  .not_push   (not_push),
  .ev_accept  (ev_accept),
  .ev_start   (ev_start),
  .ev_fire    (ev_fire),
  .ev_last    (ev_last)
);

// File: tb/sim_stack_push_seq.sv
module sim_stack_push_seq;
  localparam int PERIOD = 10;
  localparam logic [31:0] SP_INIT = 32'h0000_8000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn_word = '0;
  logic        insn_form = 1'b0;
  logic        insn_pass = 1'b1;
  logic        insn_ready;
  logic [31:0] sp_rdata;
  logic [3:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic        mem_wvalid;
  logic        mem_wready = 1'b0;
  logic [31:0] mem_waddr;
  logic [31:0] mem_wdata;
  logic        sp_we;
  logic [31:0] sp_wdata;
  logic        done;
  logic        not_push;

  logic [31:0] regs [16];
  int nchk = 0;
  int nfail = 0;

  always #(PERIOD/2) clk = ~clk;

  assign rf_rdata = regs[rf_raddr];
  assign sp_rdata = regs[13];

  stack_push_seq u0 (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .insn_form(insn_form), .insn_pass(insn_pass), .insn_ready(insn_ready),
    .sp_rdata(sp_rdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata),
    .done(done), .not_push(not_push)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model of the decode rules
  function automatic bit model_decode(input logic [31:0] w, input logic form,
                                      output logic [15:0] lst);
    bit ok;
    if (form) begin
      ok  = ((w & 32'hFFFF_A000) == 32'hE92D_0000);
      lst = {2'b00, w[13:0]} & 16'h1FFF;
      if (w[14]) lst = lst | 16'h4000;
    end else begin
      ok  = ((w & 32'h0FFF_0000) == 32'h092D_0000) && (w[31:28] != 4'hF);
      lst = w[15:0];
    end
    return ok && ($countones(lst) > 1);
  endfunction

  task automatic run_case(input string name, input logic [31:0] w, input logic form,
                          input logic pass, input logic [7:0] stall, input bit noise);
    logic [15:0] lst;
    bit          push;
    int          n;
    int          order [16];
    int          nst;
    int          cyc;
    bit          got_done;
    logic [31:0] base;
    push = model_decode(w, form, lst);
    n = 0;
    for (int i = 0; i < 16; i++) if (lst[i]) begin order[n] = i; n++; end
    base = SP_INIT - 32'(4 * n);
    @(negedge clk);
    insn_word = w; insn_form = form; insn_pass = pass; insn_valid = 1'b1;
    #1 chk({name, " R10 ready when idle"}, 32'(insn_ready), 32'd1);
    @(negedge clk);
    if (noise) insn_word = 32'hE92D_FFFF;
    else insn_valid = 1'b0;
    cyc = 0; nst = 0; got_done = 0;
    while (!got_done && cyc < 300) begin
      mem_wready = ~stall[cyc % 8];
      #1;
      if (mem_wvalid)
        chk({name, " R10 busy not ready"}, 32'(insn_ready), 32'd0);
      if (mem_wvalid && mem_wready) begin
        if (nst < n && push && pass) begin
          chk({name, " R6 address"}, mem_waddr, base + 32'(4 * nst));
          chk({name, " R6 order"}, 32'(rf_raddr), 32'(order[nst]));
          if (!(order[nst] == 13 && nst != 0))
            chk({name, " R7 data"}, mem_wdata, regs[order[nst]]);
        end
        nst++;
      end
      if (done) begin
        got_done = 1;
        insn_valid = 1'b0;
        chk({name, " R3 R4 not_push flag"}, 32'(not_push), 32'(!push));
        chk({name, " R9 R5 sp_we"}, 32'(sp_we), 32'(push && pass));
        if (push && pass) chk({name, " R9 sp value"}, sp_wdata, base);
      end else if (sp_we) begin
        chk({name, " R9 sp_we without done"}, 32'(sp_we), 32'd0);
      end
      cyc++;
      if (!got_done) @(negedge clk);
    end
    mem_wready = 1'b0;
    chk({name, " done seen"}, 32'(got_done), 32'd1);
    chk({name, " R6 R4 R5 store count"}, 32'(nst), (push && pass) ? 32'(n) : 32'd0);
    @(negedge clk);
    #1;
    chk({name, " R9 done single pulse"}, 32'(done | sp_we), 32'd0);
    chk({name, " R10 idle after"}, 32'(insn_ready), 32'd1);
  endtask

  task automatic t_reset();
    #1;
    chk("R11 ready after reset", 32'(insn_ready), 32'd1);
    chk("R11 no store after reset", 32'(mem_wvalid), 32'd0);
    chk("R11 no done after reset", 32'(done | sp_we), 32'd0);
  endtask

  task automatic t_word_form();
    run_case("R1 word pair",        32'hE92D_0003, 1'b0, 1'b1, 8'h00, 0);
    run_case("R1 cond zero",        32'h092D_00FF, 1'b0, 1'b1, 8'h00, 0);
    run_case("R1 cond 1111",        32'hF92D_00FF, 1'b0, 1'b1, 8'h00, 0);
    run_case("R1 wrong base",       32'hE92C_00FF, 1'b0, 1'b1, 8'h00, 0);
    run_case("R1 load bit",         32'hE93D_00FF, 1'b0, 1'b1, 8'h00, 0);
    run_case("R1 full list",        32'hE92D_FFFF, 1'b0, 1'b1, 8'h00, 0);
  endtask

  task automatic t_halfword_form();
    run_case("R2 with link",        32'hE92D_40F0, 1'b1, 1'b1, 8'h00, 0);
    run_case("R2 low thirteen",     32'hE92D_1FFF, 1'b1, 1'b1, 8'h00, 0);
    run_case("R2 bit15 set",        32'hE92D_C003, 1'b1, 1'b1, 8'h00, 0);
    run_case("R2 bit13 set",        32'hE92D_2003, 1'b1, 1'b1, 8'h00, 0);
    run_case("R2 word-only pattern",32'h692D_0003, 1'b1, 1'b1, 8'h00, 0);
  endtask

  task automatic t_count_rule();
    run_case("R3 word single",      32'hE92D_0010, 1'b0, 1'b1, 8'h00, 0);
    run_case("R3 halfword M only",  32'hE92D_4000, 1'b1, 1'b1, 8'h00, 0);
  endtask

  task automatic t_sp_in_list();
    run_case("R7 sp not lowest",    32'hE92D_2002, 1'b0, 1'b1, 8'h00, 0);
    run_case("R7 sp lowest",        32'hE92D_6000, 1'b0, 1'b1, 8'h00, 0);
  endtask

  task automatic t_stalls();
    run_case("R8 stalled stores",   32'hE92D_C030, 1'b0, 1'b1, 8'b0110_0101, 0);
  endtask

  task automatic t_pass_low();
    run_case("R5 pass low",         32'hE92D_0003, 1'b0, 1'b0, 8'h00, 0);
  endtask

  task automatic t_busy_ignore();
    run_case("R10 busy input held", 32'hE92D_000C, 1'b0, 1'b1, 8'b0000_0011, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'hA000_0000 + 32'(i) * 32'h0101_0111;
    regs[13] = SP_INIT;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_word_form();
    t_halfword_form();
    t_count_rule();
    t_sp_in_list();
    t_stalls();
    t_pass_low();
    t_busy_ignore();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule